// File: doc/BRIEF.md
# Eight-bit ALU status flag unit

This block evaluates the ten eight-bit accumulator operations of a small processor core: add, add with carry, subtract, subtract with borrow, compare, AND, XOR, OR, increment and decrement. Each operation produces a result byte and a fresh eight-bit status byte. The status byte carries the two undocumented copy bits, taken from bits 3 and 5.

The core drives the accumulator value, the second operand, a four-bit operation code and a write strobe. On a rising clock edge with the strobe high, the unit updates its flag register, and its result register when the operation writes back. A per-operation mask picks which flag bits take new values. Increment and decrement keep the old carry. The carry-using forms add the carry currently held in the flag register to the operand before they compute.

Top module: `alu8_flag_unit`

## Requirements
- R1: The flag byte is laid out from bit 0 up as carry, subtract, parity/overflow, copy3, half-carry, copy5, zero, sign. For arithmetic, carry is bit 8 of the nine-bit sum or difference. Half-carry is bit 4 of the same operation done on the low nibbles alone. The result byte is the low eight bits of that sum or difference.
- R2: For add forms, overflow is set when both operands have equal bit 7 and the result's bit 7 differs. For subtract forms, overflow is set when the operands' bit 7 differ and the result's bit 7 differs from the accumulator's.
- R3: Subtract, subtract with borrow, compare and decrement set the subtract flag (bit 1). All other operations clear it.
- R4: Zero (bit 6) is set when the result byte is 0. Sign (bit 7) equals result bit 7.
- R5: Compare (code 4) takes copy3 and copy5 from operand bits 3 and 5 and leaves the result register unchanged.
- R6: AND (5), XOR (6) and OR (7) clear carry and subtract. They put 1 in parity/overflow when the result has an even number of set bits. Half-carry is 1 for AND and 0 for XOR and OR.
- R7: Increment (8) and decrement (9) use the accumulator as the left operand and 1 as the right operand, and leave the carry bit unchanged.
- R8: Outside compare, copy3 (bit 3) and copy5 (bit 5) equal result bits 3 and 5.
- R9: With the write strobe low, neither the flags nor the result change.
- R10: Operation codes 10 to 15 leave the flags and the result unchanged.
- R11: A synchronous reset clears the flag and result registers to 0.
- R12: Add with carry (1) and subtract with borrow (3) use the operand plus the stored carry flag as a nine-bit right operand. Codes 0 and 2 are the plain add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for this cycle's operation |
| op | input | 4 | Operation code, 0 to 9 valid |
| acc_in | input | 8 | Accumulator value, left operand |
| opnd | input | 8 | Second operand |
| result | output | 8 | Registered result byte |
| flags | output | 8 | Registered status flag byte |

## Verification
Every accumulator value is combined with sixteen operand values around the nibble and sign boundaries (0x00, 0x0F, 0x10, 0x7F, 0x80, 0xFF and others). Every one of the sixteen operation codes is issued on each pair. This separates the carry, half-carry and overflow edges for add and subtract. The stored carry state varies from cycle to cycle, so the carry-using forms run with both carry values, and the 0xFF-plus-carry case produces a nine-bit operand. The write strobe is dropped on a rotating subset of cycles, and the unused codes sit inside the same stream, so a stray update shows up in the next comparison. A reset in mid-stream checks that both registers clear.

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit #(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [OP_W-1:0] op,
  input  logic [7:0]      acc_in,
  input  logic [7:0]      opnd,
  output logic [7:0]      result,
  output logic [7:0]      flags
);

  localparam logic [OP_W-1:0] OP_ADD = 0;
  localparam logic [OP_W-1:0] OP_ADC = 1;
  localparam logic [OP_W-1:0] OP_SUB = 2;
  localparam logic [OP_W-1:0] OP_SBC = 3;
  localparam logic [OP_W-1:0] OP_CMP = 4;
  localparam logic [OP_W-1:0] OP_AND = 5;
  localparam logic [OP_W-1:0] OP_XOR = 6;
  localparam logic [OP_W-1:0] OP_OR  = 7;
  localparam logic [OP_W-1:0] OP_INC = 8;
  localparam logic [OP_W-1:0] OP_DEC = 9;

  logic       step, use_cin, is_sub, is_logic, is_valid, ovf;
  logic [8:0] rhs, arith;
  logic [4:0] nib;
  logic [7:0] lres, res_n, xbits, new_flags, mask;

  assign step     = (op == OP_INC) || (op == OP_DEC);
  assign use_cin  = (op == OP_ADC) || (op == OP_SBC);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
  assign is_logic = (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
  assign is_valid = op <= OP_DEC;

  assign rhs   = step ? 9'd1 : ({1'b0, opnd} + {8'd0, use_cin & flags[0]});
  assign arith = is_sub ? ({1'b0, acc_in} - rhs) : ({1'b0, acc_in} + rhs);
  assign nib   = is_sub ? ({1'b0, acc_in[3:0]} - {1'b0, rhs[3:0]})
                        : ({1'b0, acc_in[3:0]} + {1'b0, rhs[3:0]});
  assign ovf   = is_sub ? ((acc_in[7] != rhs[7]) && (arith[7] != acc_in[7]))
                        : ((acc_in[7] == rhs[7]) && (arith[7] != acc_in[7]));

  always_comb begin
    case (op)
      OP_AND:  lres = acc_in & opnd;
      OP_XOR:  lres = acc_in ^ opnd;
      default: lres = acc_in | opnd;
    endcase
  end

  assign res_n = is_logic ? lres : arith[7:0];
  assign xbits = (op == OP_CMP) ? opnd : res_n;
  assign mask  = step ? 8'hFE : 8'hFF;

  assign new_flags = {res_n[7],
                      res_n == 8'd0,
                      xbits[5],
                      is_logic ? (op == OP_AND) : nib[4],
                      xbits[3],
                      is_logic ? ~^res_n : ovf,
                      is_sub,
                      is_logic ? 1'b0 : arith[8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= 8'd0;
      result <= 8'd0;
    end else if (wr_en && is_valid) begin
      flags <= (new_flags & mask) | (flags & ~mask);
      if (op != OP_CMP) result <= res_n;
    end
  end

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (flags == 8'd0) && (result == 8'd0));

  assert_hold_nowr_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(flags) && $stable(result));

  assert_unused_code_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op > OP_DEC) |=> $stable(flags) && $stable(result));

  assert_keep_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && step) |=> flags[0] == $past(flags[0]));

  assert_cmp_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_CMP) |=> $stable(result));

  assert_zero_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_valid && op != OP_CMP) |=>
      (flags[6] == (result == 8'd0)) && (flags[7] == result[7]));

  assert_logic_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_logic) |=> flags[1:0] == 2'b00);

  assert_sub_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_valid) |=> flags[1] == $past(is_sub));

endmodule

// File: tb/alu8_flag_unit_bench.sv
module alu8_flag_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc_in = 8'd0;
  logic [7:0] opnd = 8'd0;
  logic [7:0] result, flags;

  int n_tests = 0;
  int n_fail = 0;
  int m_flags = 0;
  int m_res = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flag_unit u_alu8_flag_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op(op),
    .acc_in(acc_in), .opnd(opnd), .result(result), .flags(flags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%02h b=%02h actual=%02h expected=%02h",
               tag, op, acc_in, opnd, act, exp);
    end
  endtask

  function automatic int par_even(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  // updates the model registers m_flags/m_res from the current inputs
  task automatic model_step(input bit w, input int o, input int a, input int b);
    int rh, r, res, c, h, v, n, x, nf;
    bit sub, logic_op;
    if (!w || o > 9) return;
    sub = (o == 2 || o == 3 || o == 4 || o == 9);
    logic_op = (o >= 5 && o <= 7);
    if (o == 8 || o == 9) rh = 1;
    else if (o == 1 || o == 3) rh = b + (m_flags & 1);
    else rh = b;
    if (logic_op) begin
      res = (o == 5) ? (a & b) : (o == 6) ? (a ^ b) : (a | b);
      c = 0; h = (o == 5); v = par_even(res);
    end else begin
      r = sub ? (a - rh) : (a + rh);
      res = r & 255;
      c = (r >> 8) & 1;
      h = sub ? ((((a & 15) - (rh & 15)) >> 4) & 1) : ((((a & 15) + (rh & 15)) >> 4) & 1);
      v = sub ? ((((a ^ rh) & (a ^ res) & 128) != 0) ? 1 : 0)
              : ((((a ^ res) & (rh ^ res) & 128) != 0) ? 1 : 0);
    end
    n = sub;
    x = (o == 4) ? b : res;
    nf = c + 2*n + 4*v + (x & 8) + 16*h + (x & 32) + ((res == 0) ? 64 : 0) + (res & 128);
    if (o == 8 || o == 9) nf = (nf & 254) | (m_flags & 1);
    m_flags = nf;
    if (o != 4) m_res = res;
  endtask

  task automatic compare_all(input bit w, input int o);
    string rt, ct, vt, xt, ht;
    if (!w) begin
      chk("R9 flags", flags, m_flags); chk("R9 result", result, m_res); return;
    end
    if (o > 9) begin
      chk("R10 flags", flags, m_flags); chk("R10 result", result, m_res); return;
    end
    rt = (o == 1 || o == 3) ? "R12 result" : (o == 4) ? "R5 result" :
         (o >= 5 && o <= 7) ? "R6 result" : (o >= 8) ? "R7 result" : "R1 result";
    ct = (o >= 8) ? "R7 carry" : (o >= 5 && o <= 7) ? "R6 carry" : "R1 carry";
    vt = (o >= 5 && o <= 7) ? "R6 parity" : "R2 overflow";
    xt = (o == 4) ? "R5 copybits" : "R8 copybits";
    ht = (o >= 5 && o <= 7) ? "R6 half" : "R1 half";
    chk(rt, result, m_res);
    chk(ct, flags[0], m_flags & 1);
    chk("R3 subtract", flags[1], (m_flags >> 1) & 1);
    chk(vt, flags[2], (m_flags >> 2) & 1);
    chk(xt, {flags[5], flags[3]}, ((m_flags >> 4) & 2) | ((m_flags >> 3) & 1));
    chk(ht, flags[4], (m_flags >> 4) & 1);
    chk("R4 zero_sign", flags[7:6], (m_flags >> 6) & 3);
  endtask

  task automatic issue(input bit w, input int o, input int a, input int b);
    wr_en = w; op = o[3:0]; acc_in = a[7:0]; opnd = b[7:0];
    model_step(w, o, a, b);
    @(posedge clk); #1;
    compare_all(w, o);
  endtask

  initial begin
    int bvals[16] = '{8'h00, 8'h01, 8'h07, 8'h0F, 8'h10, 8'h1F, 8'h3C, 8'h5A,
                      8'h7F, 8'h80, 8'h81, 8'h9D, 8'hC3, 8'hE8, 8'hFE, 8'hFF};
    repeat (2) @(posedge clk);
    #1;
    chk("R11 flags", flags, 0); chk("R11 result", result, 0);
    rst = 1'b0;
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 16; k++) begin
        for (int o = 0; o < 16; o++) begin
          issue(((a + k + o) % 5) != 0, o, a, bvals[(k + o) % 16]);
        end
      end
      if (a == 128) begin
        rst = 1'b1; wr_en = 1'b0;
        @(posedge clk); #1;
        m_flags = 0; m_res = 0;
        chk("R11 flags", flags, 0); chk("R11 result", result, 0);
        rst = 1'b0;
      end
    end
    // directed: 0xFF plus stored carry forms a nine-bit operand
    issue(1, 2, 8'h00, 8'h01);
    issue(1, 1, 8'h10, 8'hFF);
    issue(1, 2, 8'h00, 8'h01);
    issue(1, 3, 8'h10, 8'hFF);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule